// File: doc/BRIEF.md
# Pseudo-Random Pulse-Density DAC Modulator

This block drives a single digital pin whose average value, once smoothed by an external RC low-pass network, becomes an analogue voltage. Software programs a high-count value N of W bits (16 by default). In every conversion period the block drives the pin high for exactly N one-clock slots. The pulses are scattered pseudo-randomly across the period, so the filtered output ripples less than it would if the pulses formed one block. The scatter pattern changes from one period to the next, but the pulse count never does.

In non-return-to-zero operation a period is 2^W clocks and pulses may fall in adjacent slots. In return-to-zero operation every second clock is forced low. This doubles the period to 2^(W+1) clocks, guarantees a low gap after every pulse and limits the average output to half scale. A one-cycle strobe marks the final clock of each period.

The high count and the mode are sampled only on the first clock of a period. Values written later take effect at the next period boundary. All pins are plain control and status signals, so the block has no streaming handshake.

Top module: `pdm_dac`

## Requirements
- R1: While reset is held, and on the first clock after it is released with `en` low, `dout` and `period_done` are 0.
- R2: In NRZ mode (`rtz`=0) a conversion period lasts 2^W clocks and `dout` is high in exactly N of them, where N is the `level` value in effect for that period.
- R3: In RTZ mode (`rtz`=1) a period lasts 2^(W+1) clocks and `dout` is high in exactly N of them. Counting clocks from 0 at the start of the period, every odd-numbered clock is low, so two consecutive clocks are never both high.
- R4: `period_done` is high for exactly one clock: the final clock of each period, in the same cycle as that clock's `dout` value. It is low on every other clock.
- R5: `level` and `rtz` are sampled only on the first clock of a period. A change made partway through a period leaves that period's count and length unchanged and applies from the next period.
- R6: With the same N in two consecutive periods, 0 < N < 2^W, the two pulse patterns differ.
- R7: The pulses are spread over the period. With N = 2^(W-1) in NRZ mode, the high clocks form more than one run.
- R8: NRZ mode allows pulses in adjacent clocks. With N = 2^W-1, at least two consecutive clocks are both high.
- R9: While `en` is low, `dout` and `period_done` are 0 from the next clock onward. When `en` rises again, a fresh period starts on that clock with a full length and an exact count.
- R10: With N = 0 the output stays low for a whole period, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low idles the output and restarts the period |
| level | input | W | High-count value N for the next period |
| rtz | input | 1 | 1 selects return-to-zero, 0 selects non-return-to-zero |
| dout | output | 1 | Pulse-density output bit |
| period_done | output | 1 | One-clock strobe on the final clock of each period |

## Verification
The bench concentrates on the ends of the range. N = 0 must give a silent period, and a comparator that used `<=` instead of `<` would leak one pulse. N = 2^W-1 must give one low slot and adjacent highs. A design that lost the all-zero sequence state would be off by one in the count, and a wrong boundary decode would strobe `period_done` one clock early or late. The bench changes `level` and `rtz` in the middle of a period. A design that latched them on every clock would mix two counts into one period, and one that forgot to latch the mode would end an RTZ period at the NRZ length. The bench also compares back-to-back periods at the same N, which catches a key that never advances, and it drops `en` mid-period, which exposes a design that resumes an old period instead of starting a fresh one.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  typedef enum logic {
    MODE_NRZ = 1'b0,
    MODE_RTZ = 1'b1
  } pdm_mode_e;

  // Odd constants: multiplying by an odd number modulo 2^W is a bijection.
  localparam logic [31:0] MIX_MULT = 32'h9E37_79B1;
  // Key sequence: x' = 5x + odd, which has a full period modulo 2^W.
  localparam logic [31:0] KEY_MULT = 32'd5;
  localparam logic [31:0] KEY_INC  = 32'h3C6E_F35F;
  localparam logic [31:0] KEY_SEED = 32'hACE1_2B5D;

endpackage

// File: rtl/pdm_slot_timer.sv
// Walks the slot index through every value once per period. In RTZ mode
// each slot lasts two clocks: a live half followed by a forced-low half.
module pdm_slot_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         rtz_mode,
  output logic [W-1:0] slot,
  output logic         blank_half,
  output logic         at_start,
  output logic         last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot       <= '0;
      blank_half <= 1'b0;
    end else if (!en) begin
      slot       <= '0;
      blank_half <= 1'b0;
    end else if (rtz_mode) begin
      blank_half <= ~blank_half;
      if (blank_half) slot <= slot + 1'b1;
    end else begin
      blank_half <= 1'b0;
      slot       <= slot + 1'b1;
    end
  end

  assign at_start = (slot == '0) && !blank_half;
  assign last     = rtz_mode ? ((&slot) && blank_half) : (&slot);

endmodule

// File: rtl/pdm_key_reg.sv
// Per-period scramble key; steps once at each period boundary.
module pdm_key_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  output logic [W-1:0] key
);
  import pdm_pkg::*;

  localparam logic [W-1:0] KM   = KEY_MULT[W-1:0];
  localparam logic [W-1:0] KI   = KEY_INC[W-1:0];
  localparam logic [W-1:0] SEED = KEY_SEED[W-1:0];

  logic [W-1:0] key_nxt;
  assign key_nxt = key * KM + KI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       key <= SEED;
    else if (advance) key <= key_nxt;
  end

endmodule

// File: rtl/pdm_slot_map.sv
// One-to-one scramble of the slot index, then threshold against N.
// The map is a bijection, so exactly N slots per period fall below N.
module pdm_slot_map #(
  parameter int W = 16
) (
  input  logic [W-1:0] slot,
  input  logic [W-1:0] key,
  input  logic [W-1:0] thresh,
  input  logic         blank,
  output logic         hit
);
  import pdm_pkg::*;

  localparam logic [W-1:0] MM = MIX_MULT[W-1:0];

  logic [W-1:0] rev;
  logic [W-1:0] scr;
  logic [W-1:0] mixed;

  for (genvar g = 0; g < W; g++) begin : g_rev
    assign rev[g] = slot[W-1-g];
  end

  assign scr   = rev ^ key;
  assign mixed = scr * MM;
  assign hit   = !blank && (mixed < thresh);

endmodule

// File: rtl/pdm_dac.sv
module pdm_dac #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] level,
  input  logic         rtz,
  output logic         dout,
  output logic         period_done
);
  import pdm_pkg::*;

  logic [W-1:0] lvl_q;
  pdm_mode_e    mode_q;
  pdm_mode_e    mode_eff;
  logic [W-1:0] lvl_eff;
  logic [W-1:0] slot;
  logic [W-1:0] key;
  logic         blank_half;
  logic         at_start;
  logic         last;
  logic         hit;
  logic         rtz_eff;

  // On the first clock of a period the live inputs steer the slot logic.
  assign mode_eff = at_start ? pdm_mode_e'(rtz) : mode_q;
  assign lvl_eff  = at_start ? level : lvl_q;
  assign rtz_eff  = (mode_eff == MODE_RTZ);

  pdm_slot_timer #(.W(W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .rtz_mode   (rtz_eff),
    .slot       (slot),
    .blank_half (blank_half),
    .at_start   (at_start),
    .last       (last)
  );

  pdm_key_reg #(.W(W)) u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (en && last),
    .key     (key)
  );

  pdm_slot_map #(.W(W)) u_map (
    .slot   (slot),
    .key    (key),
    .thresh (lvl_eff),
    .blank  (rtz_eff && blank_half),
    .hit    (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q       <= '0;
      mode_q      <= MODE_NRZ;
      dout        <= 1'b0;
      period_done <= 1'b0;
    end else begin
      dout        <= en && hit;
      period_done <= en && last;
      if (en && at_start) begin
        lvl_q  <= level;
        mode_q <= mode_eff;
      end
    end
  end

endmodule

// File: rtl/pdm_dac_chk.sv
module pdm_dac_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         dout,
  input logic         period_done,
  input logic [W-1:0] lvl_q,
  input logic         mode_q,
  input logic         at_start
);

  localparam int CW = W + 2;
  localparam logic [CW-1:0] LEN_NRZ = CW'(1) << W;
  localparam logic [CW-1:0] LEN_RTZ = CW'(1) << (W + 1);

  logic          en_d;
  logic [CW-1:0] cyc;
  logic [W:0]    hc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d <= 1'b0;
      cyc  <= '0;
      hc   <= '0;
    end else begin
      en_d <= en;
      if (!en_d || period_done) begin
        cyc <= '0;
        hc  <= '0;
      end else begin
        cyc <= cyc + CW'(1);
        hc  <= hc + (W+1)'(dout);
      end
    end
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!dout && !period_done));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |=> !period_done);

  // R4
  period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_d && period_done) |-> ((cyc + CW'(1)) == (mode_q ? LEN_RTZ : LEN_NRZ)));

  // R2
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_d && period_done) |-> ((hc + (W+1)'(dout)) == {1'b0, lvl_q}));

  // R3
  rtz_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout && $past(dout) && !$past(period_done)) |-> !mode_q);

  // R5
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> $past(en && at_start));

endmodule

bind pdm_dac pdm_dac_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .dout        (dout),
  .period_done (period_done),
  .lvl_q       (lvl_q),
  .mode_q      (mode_q),
  .at_start    (at_start)
);

// File: tb/sim_pdm_dac.sv
`timescale 1ns/1ps
module sim_pdm_dac;

  localparam int W    = 8;
  localparam int PN   = 1 << W;
  localparam int PR   = 1 << (W + 1);
  localparam int FULL = PN - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] level = '0;
  logic         rtz = 1'b0;
  logic         dout;
  logic         period_done;

  int checks = 0;
  int fails  = 0;
  logic dbuf [0:PR-1];
  logic dnb  [0:PR-1];
  logic prev [0:PR-1];
  int   cur_lvl = 0;
  logic cur_rtz = 1'b0;

  always #2.5 clk = ~clk;

  pdm_dac #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .level(level), .rtz(rtz),
    .dout(dout), .period_done(period_done)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int plen(input logic r);
    return r ? PR : PN;
  endfunction

  // Capture one period at the current settings; program the next at mid-period.
  task automatic run(input int nlvl, input logic nrtz, input string req);
    int len = plen(cur_rtz);
    int hi = 0;
    int bad_done = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      dbuf[i] = dout;
      dnb[i]  = period_done;
      if (i == len / 3) begin
        level = nlvl[W-1:0];
        rtz   = nrtz;
      end
    end
    for (int i = 0; i < len; i++) begin
      if (dbuf[i]) hi++;
      if (dnb[i] != (i == len - 1)) bad_done++;
    end
    chk(hi == cur_lvl, {req, " R2/R3 pulse count"}, hi, cur_lvl);
    chk(bad_done == 0, "R4 done strobe placement", bad_done, 0);
    if (cur_rtz) begin
      int odd_hi = 0;
      for (int i = 1; i < len; i += 2) if (dbuf[i]) odd_hi++;
      chk(odd_hi == 0, "R3 odd clocks low in RTZ", odd_hi, 0);
    end
    cur_lvl = nlvl;
    cur_rtz = nrtz;
  endtask

  function automatic int runs_of_high(input int len);
    int r = 0;
    for (int i = 0; i < len; i++)
      if (dbuf[i] && (i == 0 || !dbuf[i-1])) r++;
    return r;
  endfunction

  function automatic int adjacent_highs(input int len);
    int a = 0;
    for (int i = 1; i < len; i++) if (dbuf[i] && dbuf[i-1]) a++;
    return a;
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int diff;
    int quiet;
    void'($urandom(32'd20240611));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(dout == 1'b0 && period_done == 1'b0, "R1 outputs during reset", dout, 0);
    rst_n = 1'b1;
    level = 8'd90;
    @(negedge clk);
    chk(dout == 1'b0 && period_done == 1'b0, "R1 outputs after reset", dout, 0);

    // R9: idle with a nonzero level
    quiet = 0;
    repeat (20) begin @(negedge clk); if (dout || period_done) quiet++; end
    chk(quiet == 0, "R9 idle output", quiet, 0);

    // NRZ, N=100 twice, then N=128
    level = 8'd100; rtz = 1'b0; cur_lvl = 100; cur_rtz = 1'b0;
    en = 1'b1;
    run(100, 1'b0, "R2 nrz n100");
    for (int i = 0; i < PN; i++) prev[i] = dbuf[i];
    run(128, 1'b0, "R2 nrz n100 again");
    diff = 0;
    for (int i = 0; i < PN; i++) if (prev[i] != dbuf[i]) diff++;
    chk(diff > 0, "R6 pattern changes", diff, 1);
    run(FULL, 1'b0, "R2 nrz half");
    chk(runs_of_high(PN) > 1, "R7 pulses spread", runs_of_high(PN), 2);
    run(0, 1'b0, "R2 nrz full");
    chk(adjacent_highs(PN) > 0, "R8 adjacent highs in NRZ", adjacent_highs(PN), 1);
    run(200, 1'b1, "R10 nrz zero");
    chk(runs_of_high(PN) == 0, "R10 silent period", runs_of_high(PN), 0);

    // RTZ periods
    run(FULL, 1'b1, "R3 rtz n200");
    chk(adjacent_highs(PR) == 0, "R3 no adjacent highs", adjacent_highs(PR), 0);
    run(0, 1'b1, "R3 rtz full");
    chk(adjacent_highs(PR) == 0, "R3 no adjacent highs full", adjacent_highs(PR), 0);
    run(37, 1'b0, "R10 rtz zero");
    chk(runs_of_high(PR) == 0, "R10 silent rtz period", runs_of_high(PR), 0);
    // R5: switch back to NRZ mid-RTZ was applied only now
    run(37, 1'b0, "R5 mode switch lands at boundary");

    // Constrained random periods
    for (int k = 0; k < 8; k++) begin
      int nl = $urandom_range(FULL, 0);
      logic nr = 1'($urandom_range(1, 0));
      run(nl, nr, "R5 random");
    end

    // R9: drop enable mid-period, then restart fresh
    repeat (40) @(negedge clk);
    en = 1'b0;
    quiet = 0;
    @(negedge clk);
    repeat (10) begin @(negedge clk); if (dout || period_done) quiet++; end
    chk(quiet == 0, "R9 quiet after disable", quiet, 0);
    level = 8'd37; rtz = 1'b0; cur_lvl = 37; cur_rtz = 1'b0;
    en = 1'b1;
    run(5, 1'b1, "R9 restart");
    run(5, 1'b1, "R9 following period");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule